// File: doc/BRIEF.md
# Preset Countdown Minute-Second Timer

This block holds a countdown value in minutes and seconds and counts it down by one second on every tick strobe while the run enable is high. All registers sit on one system clock. The one-second tick and the button pulses are single-cycle clock enables that come from logic outside the block, which already handles clock division and debouncing. The value goes out as two BCD digit pairs, together with a flag that is high while the count is at 00:00.

The count is set in two ways. The first is a synchronous reset, which loads either 00:00 or one of three preset cooking durations chosen by switches (soft, medium and hard). The second is a pair of increment pulses, one for the minutes field and one for the seconds field. Each field wraps on its own from 59 back to 00, so any value up to 59:59 can be reached. When several controls arrive in the same cycle, the block applies a fixed priority.

Top module: `preset_countdown_timer`

## Requirements
- R1: Each output is two BCD digits: bits [7:4] hold the tens digit and bits [3:0] hold the ones digit. After reset, the minutes value and the seconds value each stay within 00..59.
- R2: An `inc_sec` pulse adds one to the seconds and wraps 59 to 00 without touching the minutes. An `inc_min` pulse adds one to the minutes and wraps 59 to 00 without touching the seconds. When both pulses arrive in the same cycle, both fields change.
- R3: A reset with no preset switch on loads 00:00.
- R4: A reset with exactly one preset switch on loads that preset: `preset_sel[0]` gives 06:00, `preset_sel[1]` gives 09:00 and `preset_sel[2]` gives 12:00.
- R5: A reset with two or more preset switches on loads 00:00.
- R6: A tick with `run_en` high and a nonzero count removes one second. When the seconds are at 00, the seconds become 59 and the minutes drop by one.
- R7: A tick has no effect while the count is 00:00.
- R8: While `run_en` is low, ticks change nothing, but increment pulses still take effect.
- R9: Reset wins over increments and ticks in the same cycle. An increment wins over a tick in the same cycle, and that tick is dropped.
- R10: `at_zero` is high in the same cycle as the outputs read 00:00, and low at every other count.
- R11: Every change appears at the outputs one clock edge after the control that causes it. With no control active, the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high, loads 00:00 or a preset |
| run_en | input | 1 | Countdown enable |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| inc_min | input | 1 | One-cycle pulse that adds one minute |
| inc_sec | input | 1 | One-cycle pulse that adds one second |
| preset_sel | input | 3 | Preset switches: bit0 soft, bit1 medium, bit2 hard |
| min_bcd | output | 8 | Minutes as two BCD digits |
| sec_bcd | output | 8 | Seconds as two BCD digits |
| at_zero | output | 1 | High while the count is 00:00 |

## Verification
Two functions can land in the same clock cycle: a manual increment and the one-second decrement. Reset can also coincide with both of them. Directed cycles place a tick on the same edge as `inc_sec`, as `inc_min`, and as a preset reset. A long pseudo-random stretch then mixes all of these controls freely. The outputs after each edge are compared with an arithmetic model in the bench that applies reset, then increments, then the tick, so a dropped increment or a tick that leaks through shows up as a wrong count.

// File: rtl/pct_pkg.sv
package pct_pkg;

   typedef struct packed {
      logic [3:0] tens;
      logic [3:0] ones;
   } bcd2_t;

   // Binary 0..99 to a two-digit BCD pair.
   function automatic bcd2_t to_bcd2(input int unsigned v);
      bcd2_t r;
      r.tens = 4'((v / 10) % 10);
      r.ones = 4'(v % 10);
      return r;
   endfunction

endpackage

// File: rtl/pct_bcd_pair.sv
module pct_bcd_pair
   import pct_pkg::*;
#(
   parameter int unsigned LIMIT = 59
) (
   input  logic  clk,
   input  logic  load,
   input  bcd2_t load_val,
   input  logic  inc,
   input  logic  dec,
   output bcd2_t value,
   output logic  is_zero
);

   localparam bcd2_t TOP_V = to_bcd2(LIMIT);

   generate
      if (LIMIT < 1 || LIMIT > 99) begin : g_bad_limit
         $error("pct_bcd_pair: LIMIT must lie in 1..99");
      end
   endgenerate

   bcd2_t nxt;

   always_comb begin
      nxt = value;
      if (load) begin
         nxt = load_val;
      end else if (inc) begin
         if (value == TOP_V) begin
            nxt = '0;
         end else if (value.ones == 4'd9) begin
            nxt.tens = value.tens + 4'd1;
            nxt.ones = 4'd0;
         end else begin
            nxt.ones = value.ones + 4'd1;
         end
      end else if (dec) begin
         if (value == '0) begin
            nxt = TOP_V;
         end else if (value.ones == 4'd0) begin
            nxt.tens = value.tens - 4'd1;
            nxt.ones = 4'd9;
         end else begin
            nxt.ones = value.ones - 4'd1;
         end
      end
   end

   always_ff @(posedge clk) begin
      value <= nxt;
   end

   assign is_zero = (value == '0);

endmodule

// File: rtl/pct_preset_decode.sv
module pct_preset_decode
   import pct_pkg::*;
#(
   parameter int unsigned NUM_PRESETS = 3,
   parameter int unsigned LIMIT       = 59,
   parameter logic [NUM_PRESETS*8-1:0] PRESET_MINS = {8'd12, 8'd9, 8'd6}
) (
   input  logic [NUM_PRESETS-1:0] sel,
   output bcd2_t                  load_min
);

   bcd2_t masked [NUM_PRESETS];

   generate
      if (NUM_PRESETS < 1) begin : g_bad_count
         $error("pct_preset_decode: NUM_PRESETS must be at least 1");
      end
      for (genvar i = 0; i < NUM_PRESETS; i++) begin : g_preset
         localparam int unsigned MINS = int'(PRESET_MINS[i*8 +: 8]);
         localparam bcd2_t PV = to_bcd2(MINS);
         if (MINS > LIMIT) begin : g_bad_preset
            $error("pct_preset_decode: preset exceeds LIMIT");
         end
         assign masked[i] = sel[i] ? PV : '0;
      end
   endgenerate

   bcd2_t merged;

   always_comb begin
      merged = '0;
      for (int i = 0; i < NUM_PRESETS; i++) begin
         merged = merged | masked[i];
      end
   end

   // Only a single active switch selects a preset; anything else yields zero.
   assign load_min = ($countones(sel) == 1) ? merged : '0;

endmodule

// File: rtl/preset_countdown_timer.sv
module preset_countdown_timer
   import pct_pkg::*;
#(
   parameter int unsigned NUM_PRESETS = 3,
   parameter int unsigned UNIT_LIMIT  = 59,
   parameter logic [NUM_PRESETS*8-1:0] PRESET_MINS = {8'd12, 8'd9, 8'd6}
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   run_en,
   input  logic                   tick_1hz,
   input  logic                   inc_min,
   input  logic                   inc_sec,
   input  logic [NUM_PRESETS-1:0] preset_sel,
   output logic [7:0]             min_bcd,
   output logic [7:0]             sec_bcd,
   output logic                   at_zero
);

   bcd2_t preset_min;
   bcd2_t min_v;
   bcd2_t sec_v;
   logic  min_zero;
   logic  sec_zero;
   logic  step;

   pct_preset_decode #(
      .NUM_PRESETS (NUM_PRESETS),
      .LIMIT       (UNIT_LIMIT),
      .PRESET_MINS (PRESET_MINS)
   ) u_preset (
      .sel      (preset_sel),
      .load_min (preset_min)
   );

   // Countdown step: tick, enabled, not at zero, and no increment this cycle.
   assign step = tick_1hz & run_en & ~at_zero & ~inc_min & ~inc_sec;

   pct_bcd_pair #(.LIMIT(UNIT_LIMIT)) u_sec (
      .clk      (clk),
      .load     (rst),
      .load_val ('0),
      .inc      (inc_sec),
      .dec      (step),
      .value    (sec_v),
      .is_zero  (sec_zero)
   );

   pct_bcd_pair #(.LIMIT(UNIT_LIMIT)) u_min (
      .clk      (clk),
      .load     (rst),
      .load_val (preset_min),
      .inc      (inc_min),
      .dec      (step & sec_zero),
      .value    (min_v),
      .is_zero  (min_zero)
   );

   assign min_bcd = min_v;
   assign sec_bcd = sec_v;
   assign at_zero = min_zero & sec_zero;

endmodule

// File: rtl/pct_checker.sv
module pct_checker
   import pct_pkg::*;
#(
   parameter int unsigned NUM_PRESETS = 3,
   parameter int unsigned LIMIT       = 59
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   run_en,
   input logic                   tick_1hz,
   input logic                   inc_min,
   input logic                   inc_sec,
   input logic [NUM_PRESETS-1:0] preset_sel,
   input logic [7:0]             min_bcd,
   input logic [7:0]             sec_bcd,
   input logic                   at_zero
);

   localparam logic [7:0] TOP_B = to_bcd2(LIMIT);

   // R1
   digits_legal_chk: assert property (@(posedge clk) disable iff (rst)
      min_bcd[3:0] <= 4'd9 && sec_bcd[3:0] <= 4'd9 &&
      min_bcd <= TOP_B && sec_bcd <= TOP_B);

   // R10
   zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
      at_zero == (min_bcd == 8'h00 && sec_bcd == 8'h00));

   // R3
   reset_zero_load_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) && $countones($past(preset_sel)) != 1 |->
         min_bcd == 8'h00 && sec_bcd == 8'h00);

   // R7
   zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(at_zero) && !$past(inc_min) && !$past(inc_sec)
         |-> at_zero);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(inc_min) && !$past(inc_sec) &&
      !($past(tick_1hz) && $past(run_en)) |-> $stable(min_bcd) && $stable(sec_bcd));

   // R2
   sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(inc_sec) && $past(sec_bcd) == TOP_B |-> sec_bcd == 8'h00);

   // R9
   inc_beats_tick_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(inc_sec) && !$past(inc_min) |-> $stable(min_bcd));

endmodule

bind preset_countdown_timer pct_checker #(
   .NUM_PRESETS (NUM_PRESETS),
   .LIMIT       (UNIT_LIMIT)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .run_en     (run_en),
   .tick_1hz   (tick_1hz),
   .inc_min    (inc_min),
   .inc_sec    (inc_sec),
   .preset_sel (preset_sel),
   .min_bcd    (min_bcd),
   .sec_bcd    (sec_bcd),
   .at_zero    (at_zero)
);

// File: tb/preset_countdown_timer_test.sv
module preset_countdown_timer_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       run_en = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       inc_min = 1'b0;
   logic       inc_sec = 1'b0;
   logic [2:0] preset_sel = 3'b000;
   logic [7:0] min_bcd;
   logic [7:0] sec_bcd;
   logic       at_zero;

   int n_cmp = 0;
   int n_bad = 0;
   int m_ref = 0;
   int s_ref = 0;

   always #2 clk = ~clk;

   preset_countdown_timer uut (
      .clk        (clk),
      .rst        (rst),
      .run_en     (run_en),
      .tick_1hz   (tick_1hz),
      .inc_min    (inc_min),
      .inc_sec    (inc_sec),
      .preset_sel (preset_sel),
      .min_bcd    (min_bcd),
      .sec_bcd    (sec_bcd),
      .at_zero    (at_zero)
   );

   function automatic logic [7:0] to_b(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Reference: reset, then increments, then tick (R9).
   task automatic model(input bit r, input bit e, input bit t, input bit im,
                        input bit is, input logic [2:0] sel);
      if (r) begin
         s_ref = 0;
         case (sel)
            3'b001:  m_ref = 6;
            3'b010:  m_ref = 9;
            3'b100:  m_ref = 12;
            default: m_ref = 0;
         endcase
      end else if (im || is) begin
         if (im) m_ref = (m_ref == 59) ? 0 : m_ref + 1;
         if (is) s_ref = (s_ref == 59) ? 0 : s_ref + 1;
      end else if (t && e && (m_ref != 0 || s_ref != 0)) begin
         if (s_ref > 0) begin
            s_ref = s_ref - 1;
         end else begin
            s_ref = 59;
            m_ref = m_ref - 1;
         end
      end
   endtask

   task automatic cyc(input bit r, input bit e, input bit t, input bit im,
                      input bit is, input logic [2:0] sel, input string tag);
      logic exp_z;
      rst = r; run_en = e; tick_1hz = t; inc_min = im; inc_sec = is; preset_sel = sel;
      @(posedge clk);
      #1;
      model(r, e, t, im, is, sel);
      exp_z = (m_ref == 0 && s_ref == 0);
      n_cmp++;
      if (min_bcd !== to_b(m_ref) || sec_bcd !== to_b(s_ref) || at_zero !== exp_z) begin
         n_bad++;
         $display("FAIL %s: actual %h:%h zero=%b expected %h:%h zero=%b",
                  tag, min_bcd, sec_bcd, at_zero, to_b(m_ref), to_b(s_ref), exp_z);
      end
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL R11 watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] lf;
      #1;
      // R3 R10: reset without presets
      cyc(1, 0, 0, 0, 0, 3'b000, "R3 R10 reset no preset");
      cyc(0, 0, 0, 0, 0, 3'b000, "R11 hold after reset");
      // R4: each preset alone
      for (int i = 0; i < 3; i++) begin
         cyc(1, 0, 0, 0, 0, 3'(1 << i), "R4 single preset");
         cyc(0, 1, 1, 0, 0, 3'b000, "R6 first tick after preset");
      end
      // R5: multiple presets
      cyc(1, 0, 0, 0, 0, 3'b011, "R5 two presets");
      cyc(1, 0, 0, 0, 0, 3'b101, "R5 two presets");
      cyc(1, 0, 0, 0, 0, 3'b110, "R5 two presets");
      cyc(1, 0, 0, 0, 0, 3'b111, "R5 all presets");
      // R2 R1: full seconds and minutes sweeps with wrap
      for (int i = 0; i < 61; i++) cyc(0, 0, 0, 0, 1, 3'b000, "R2 R1 seconds sweep");
      for (int i = 0; i < 61; i++) cyc(0, 0, 0, 1, 0, 3'b000, "R2 R1 minutes sweep");
      for (int i = 0; i < 60; i++) cyc(0, 0, 0, 1, 1, 3'b000, "R2 both fields");
      // R6 R7: countdown 02:03 through zero and beyond
      cyc(1, 0, 0, 0, 0, 3'b000, "R3 reload zero");
      cyc(0, 0, 0, 1, 0, 3'b000, "R8 inc while disabled");
      cyc(0, 0, 0, 1, 0, 3'b000, "R8 inc while disabled");
      for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 3'b000, "R8 inc while disabled");
      for (int i = 0; i < 130; i++) cyc(0, 1, 1, 0, 0, 3'b000, "R6 R7 countdown");
      cyc(0, 1, 1, 0, 0, 3'b000, "R7 tick at zero");
      // R8: disabled ticks
      cyc(1, 0, 0, 0, 0, 3'b010, "R4 medium preset");
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, 3'b000, "R8 tick disabled");
      for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, 3'b000, "R11 enabled no tick");
      // R9: same-cycle priorities
      cyc(0, 1, 1, 0, 1, 3'b000, "R9 inc_sec beats tick");
      cyc(0, 1, 1, 1, 0, 3'b000, "R9 inc_min beats tick");
      cyc(0, 1, 1, 1, 1, 3'b000, "R9 both incs beat tick");
      cyc(1, 1, 1, 1, 1, 3'b100, "R9 reset beats inc and tick");
      cyc(1, 1, 1, 1, 1, 3'b000, "R9 reset zero beats inc");
      cyc(0, 1, 1, 0, 0, 3'b000, "R7 tick at zero after reset");
      // R11: pseudo-random mix against the model
      lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         cyc(lf[4:0] == 5'h1f, lf[5] | lf[6], lf[7] | lf[8],
             lf[9] & lf[10] & lf[11], lf[12] & lf[13], lf[2:0], "R11 random mix");
      end
      finish_run();
   end

endmodule